// File: doc/BRIEF.md
# Write-Zero-Clear Interrupt Flag Register

This block holds the pending-interrupt flags of a small microcontroller peripheral group. It has one 8-bit flag register. Each live bit captures a single-cycle hardware event:

- a timer rollover,
- a serial transfer-complete indication, or
- one of five external interrupt inputs.

A flag stays set until software writes a 0 to that bit position. Writing a 1 leaves the bit alone. The CPU taking the interrupt does not clear anything.

A second 8-bit register holds one enable bit per flag. The block drives a single registered interrupt request to the CPU. That request is high when any flag is set and its enable bit is also set.

Software reaches both registers through a plain synchronous port with an address, a write strobe, write data and combinational read data. Address 0 selects the flag register and address 1 selects the enable register. The external reset is asynchronous and active-low. Inside the block its release is synchronised to the clock over two stages.

Top module: `irq_flag_reg`

## Requirements
- R1: While reset is active, and after reset has been released, the flag register reads 0x20, the enable register reads 0x00 and `irq_o` is 0.
- R2: Bit 5 of the flag register always reads 1, and bit 5 of the enable register always reads 0. Writes to bit 5 of either register have no effect.
- R3: An event pulse sets its flag on the next clock edge. The mapping is: `tmr_ovf_i` to bit 7, `ser_done_i` to bit 6, and `ext_evt_i[k]` to bit k for k = 0 to 4.
- R4: A write to address 0 clears every live flag whose write-data bit is 0 and leaves unchanged every flag whose write-data bit is 1. A write of 1 never sets a flag.
- R5: Once set, a flag stays set for any length of time, whatever `irq_o`, the enables or repeated reads do, until software clears it with a write of 0.
- R6: When an event pulse and a write of 0 hit the same flag bit in the same cycle, the flag ends up set.
- R7: `irq_o` equals the OR over all bits of (flag AND enable). It is registered, so it changes one clock after the flag or enable update that causes the change.
- R8: A write to address 1 loads the enable register, and a read of address 1 returns the stored value with bit 5 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_addr | input | 1 | Register select: 0 selects the flag register, 1 selects the enable register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| tmr_ovf_i | input | 1 | Timer rollover pulse |
| ser_done_i | input | 1 | Serial transfer-complete pulse |
| ext_evt_i | input | 5 | External interrupt event pulses |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The event inputs are swept through all 128 combinations of the seven event sources. Each readback therefore separates a wrong bit mapping from a missed capture. All 256 write-data values are applied over a fully set register, which separates write-0-clears behaviour from plain overwrite or write-1-clears behaviour. Each flag is crossed with all 256 enable values, which checks both the masking in the request and its one-cycle latency. Separate cases then cover a simultaneous set and clear, a long hold with the interrupt asserted, and a reset applied in the middle of activity.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned IRQF_REG_W    = 8;
  localparam int unsigned IRQF_RSVD_BIT = 5;
  localparam int unsigned IRQF_ADDR_W   = 1;
endpackage

// File: rtl/irqf_rst_sync.sv
module irqf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
  parameter int unsigned W    = 8,
  parameter int unsigned RSVD = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == RSVD) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = set_i[b] ^ wdata_i[b];
      assign flags_o[b]  = 1'b1;
    end else begin : g_flag
      logic q, d, en, clr;

      always_comb begin
        clr = wr_i & ~wdata_i[b];
        en  = set_i[b] | clr;
        d   = set_i[b];          // set has priority over a clear
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end

      assign flags_o[b] = q;

      a_r3_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> flags_o[b]);
      a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[b] && !(wr_i && !wdata_i[b])) |=> flags_o[b]);
      a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[b] && !set_i[b]) |=> !flags_o[b]);
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[b] && wr_i && !wdata_i[b]) |=> flags_o[b]);
      a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[b] && !set_i[b]) |=> !flags_o[b]);
    end
  end
endmodule

// File: rtl/irqf_enable_reg.sv
module irqf_enable_reg #(
  parameter int unsigned W    = 8,
  parameter int unsigned RSVD = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ena_o
);
  localparam logic [W-1:0] LIVE_MASK = ~(W'(1) << RSVD);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == RSVD) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = wdata_i[b];
      assign ena_o[b]    = 1'b0;
    end else begin : g_ena
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (wr_i) q <= wdata_i[b];
      end
      assign ena_o[b] = q;
    end
  end

  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (ena_o == ($past(wdata_i) & LIVE_MASK)));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ena_o));
endmodule

// File: rtl/irqf_req_combine.sv
module irqf_req_combine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] ena_i,
  output logic         irq_o
);
  logic irq_d, irq_q;

  always_comb irq_d = |(flags_i & ena_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_i & ena_i)) |=> irq_o);
  a_r7_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags_i & ena_i)) |=> !irq_o);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irqf_pkg::*;
#(
  parameter int unsigned REG_W     = IRQF_REG_W,
  parameter int unsigned RSVD_BIT  = IRQF_RSVD_BIT,
  parameter int unsigned ADDR_W    = IRQF_ADDR_W,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] ENA_ADDR  = ADDR_W'(1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic                tmr_ovf_i,
  input  logic                ser_done_i,
  input  logic [RSVD_BIT-1:0] ext_evt_i,
  output logic                irq_o
);
  localparam int unsigned TMR_BIT = REG_W - 1;
  localparam int unsigned SER_BIT = REG_W - 2;

  logic             rst_int_n;
  logic             wr_flag, wr_ena;
  logic [REG_W-1:0] set_vec, flags, enables;

  irqf_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  always_comb begin
    set_vec                 = '0;
    set_vec[TMR_BIT]        = tmr_ovf_i;
    set_vec[SER_BIT]        = ser_done_i;
    set_vec[RSVD_BIT-1:0]   = ext_evt_i;
    wr_flag = bus_wr && (bus_addr == FLAG_ADDR);
    wr_ena  = bus_wr && (bus_addr == ENA_ADDR);
  end

  irqf_flag_bank #(.W(REG_W), .RSVD(RSVD_BIT)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (set_vec),
    .wr_i    (wr_flag),
    .wdata_i (bus_wdata),
    .flags_o (flags)
  );

  irqf_enable_reg #(.W(REG_W), .RSVD(RSVD_BIT)) u_ena (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (wr_ena),
    .wdata_i (bus_wdata),
    .ena_o   (enables)
  );

  irqf_req_combine #(.W(REG_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .flags_i (flags),
    .ena_i   (enables),
    .irq_o   (irq_o)
  );

  always_comb begin
    if (bus_addr == FLAG_ADDR)     bus_rdata = flags;
    else if (bus_addr == ENA_ADDR) bus_rdata = enables;
    else                           bus_rdata = '0;
  end

  a_r5_read_no_effect: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_wr && set_vec == '0) |=> $stable(flags));
endmodule

// File: tb/irq_flag_reg_bench.sv
module irq_flag_reg_bench;
  logic       clk, rst_n;
  logic [0:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       tmr_ovf_i, ser_done_i;
  logic [4:0] ext_evt_i;
  logic       irq_o;
  int total = 0;
  int bad   = 0;

  irq_flag_reg u_irq_flag_reg (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf_i(tmr_ovf_i),
    .ser_done_i(ser_done_i), .ext_evt_i(ext_evt_i), .irq_o(irq_o)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic do_write(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] v);
    tmr_ovf_i = v[7]; ser_done_i = v[6]; ext_evt_i = v[4:0];
    tick();
    tmr_ovf_i = 1'b0; ser_done_i = 1'b0; ext_evt_i = 5'd0;
  endtask

  task automatic chk_reg(input logic a, input logic [7:0] exp, input string tag);
    bus_addr = a; #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s: addr %0d got %h exp %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    total++;
    if (irq_o !== exp) begin
      bad++;
      $display("FAIL %s: irq got %b exp %b", tag, irq_o, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = 8'h00;
    tmr_ovf_i = 1'b0; ser_done_i = 1'b0; ext_evt_i = 5'd0;
    repeat (3) tick();
    chk_reg(1'b0, 8'h20, "R1 flags in reset");
    chk_reg(1'b1, 8'h00, "R1 enables in reset");
    chk_irq(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    repeat (4) tick();
    chk_reg(1'b0, 8'h20, "R1 flags after reset");
    chk_reg(1'b1, 8'h00, "R1 enables after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R3: every combination of the seven event sources, then clear with zeros (R4)
    for (int v = 0; v < 128; v++) begin
      logic [6:0] vv;
      logic [7:0] pv;
      vv = 7'(v);
      pv = {vv[6:5], 1'b0, vv[4:0]};
      pulse(pv);
      chk_reg(1'b0, pv | 8'h20, "R3 event capture");
      do_write(1'b0, 8'h00);
      chk_reg(1'b0, 8'h20, "R4 clear all");
    end

    // R4: every write value over a fully set register
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mm;
      mm = 8'(m);
      pulse(8'hDF);
      do_write(1'b0, mm);
      chk_reg(1'b0, (mm & 8'hDF) | 8'h20, "R4 write-zero clear");
      do_write(1'b0, 8'h00);
    end

    // R4/R2: writing ones to a clear register sets nothing; bit 5 stays 1
    do_write(1'b0, 8'hFF);
    chk_reg(1'b0, 8'h20, "R4 write one no set");
    do_write(1'b0, 8'h00);
    chk_reg(1'b0, 8'h20, "R2 reserved reads one");

    // R6: simultaneous set and clear on the same bit, with other flags set
    for (int i = 0; i < 8; i++) begin
      logic [7:0] bit_v;
      if (i == 5) continue;
      bit_v = 8'(1 << i);
      pulse(8'hDF);
      tmr_ovf_i = bit_v[7]; ser_done_i = bit_v[6]; ext_evt_i = bit_v[4:0];
      do_write(1'b0, 8'h00);
      tmr_ovf_i = 1'b0; ser_done_i = 1'b0; ext_evt_i = 5'd0;
      chk_reg(1'b0, bit_v | 8'h20, "R6 set wins");
      do_write(1'b0, 8'h00);
    end

    // R8/R2: enable register readback
    for (int e = 0; e < 256; e++) begin
      do_write(1'b1, 8'(e));
      chk_reg(1'b1, 8'(e) & 8'hDF, "R8 enable readback");
    end

    // R7: each flag crossed with every enable value, including latency
    for (int i = 0; i < 8; i++) begin
      logic [7:0] bit_v;
      if (i == 5) continue;
      bit_v = 8'(1 << i);
      for (int e = 0; e < 256; e++) begin
        logic expv;
        expv = |(bit_v & 8'(e) & 8'hDF);
        do_write(1'b1, 8'(e));
        pulse(bit_v);
        chk_irq(1'b0, "R7 latency rise");
        tick();
        chk_irq(expv, "R7 masked request");
        do_write(1'b0, 8'h00);
        chk_irq(expv, "R7 latency fall");
        tick();
        chk_irq(1'b0, "R7 request drops");
      end
    end

    // R7: enable change alone moves irq one cycle later
    pulse(8'h01);
    do_write(1'b1, 8'h00);
    tick();
    chk_irq(1'b0, "R7 disabled");
    do_write(1'b1, 8'h01);
    chk_irq(1'b0, "R7 enable latency");
    tick();
    chk_irq(1'b1, "R7 enable raises");
    do_write(1'b0, 8'h00);

    // R5: flag held with irq asserted, enables changed, repeated reads
    do_write(1'b1, 8'hDF);
    pulse(8'h80);
    tick();
    chk_irq(1'b1, "R5 irq asserted");
    for (int k = 0; k < 20; k++) begin
      chk_reg(1'b0, 8'hA0, "R5 flag held");
      tick();
    end
    chk_irq(1'b1, "R5 irq still asserted");
    do_write(1'b1, 8'h00);
    repeat (3) tick();
    chk_reg(1'b0, 8'hA0, "R5 flag held with enable off");
    chk_irq(1'b0, "R7 irq off when disabled");

    // R1: reset in the middle of activity
    do_write(1'b1, 8'hFF);
    pulse(8'hDF);
    tick();
    rst_n = 1'b0;
    #1;
    chk_reg(1'b0, 8'h20, "R1 flags mid reset");
    chk_reg(1'b1, 8'h00, "R1 enables mid reset");
    chk_irq(1'b0, "R1 irq mid reset");
    tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk_reg(1'b0, 8'h20, "R1 flags after second reset");

    finish_run();
  end
endmodule